// File: doc/BRIEF.md
# Miss-Aware Round-Robin Warp Issue Scheduler

This block chooses, every clock cycle, which warp of a SIMD core goes to the execution pipeline. The core keeps a fixed set of warp slots. Each slot is enabled when a warp is launched into it and disabled when that warp exits. The scheduler walks the enabled slots in rotating order. After each issue the rotation restarts at the slot just after the one that was issued. Switching from one warp to another costs nothing, so a different warp may issue on every cycle.

Two kinds of long-latency wait take a warp out of the rotation. The first is an outstanding cache miss. It is raised by a miss event from the memory system and cleared by a matching fill event. The second is a wait at a block barrier. It is raised when the warp arrives at the barrier. It is cleared when the barrier logic reports, through a release mask, that every thread of the block has arrived. The rotation skips a blocked warp and takes the next ready warp in slot order. As a result, the effective issue order changes as warps block and unblock.

Events are registered at a clock edge and affect selection from the following cycle onward. The issue outputs depend only on the registered slot state and the rotation pointer.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, no slot is enabled, the rotation pointer is at slot 0, and `issue_vld` is low.
- R2: At most one warp issues per cycle. Whenever at least one enabled slot is neither miss-blocked nor barrier-blocked, `issue_vld` is high in that cycle, so ready warps issue on consecutive cycles with no gap.
- R3: The issued slot is the first ready slot found by searching upward from the rotation pointer, wrapping from slot NUM_WARPS-1 to slot 0. After an issue, the pointer moves to the issued slot plus one, wrapping to 0 after slot NUM_WARPS-1.
- R4: A miss event (`miss_vld` with `miss_id`) on an enabled slot keeps that slot from issuing, starting in the next cycle, until a fill event (`fill_vld` with `fill_id`) for the same slot arrives.
- R5: When a miss event and a fill event name the same slot in the same cycle, the fill wins and the slot is not miss-blocked afterwards.
- R6: A barrier arrival (`bar_arrive_vld` with `bar_arrive_id`) on an enabled slot keeps that slot from issuing until a cycle in which bit `i` of `bar_release_mask` is set for that slot `i`.
- R7: When an arrival and a set release bit name the same slot in the same cycle, the release wins and the slot stays eligible.
- R8: If no slot is ready, `issue_vld` is low and the rotation pointer holds its value.
- R9: A launch event enables a slot and clears any miss or barrier block it held. An exit event disables a slot. A disabled slot is never issued.
- R10: When a launch and an exit name the same slot in the same cycle, the slot ends up enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_vld | input | 1 | Enable the slot given by launch_id |
| launch_id | input | WID | Slot being launched |
| exit_vld | input | 1 | Disable the slot given by exit_id |
| exit_id | input | WID | Slot being retired |
| miss_vld | input | 1 | Long-latency miss for slot miss_id |
| miss_id | input | WID | Slot that missed |
| fill_vld | input | 1 | Miss completion for slot fill_id |
| fill_id | input | WID | Slot whose miss completed |
| bar_arrive_vld | input | 1 | Slot bar_arrive_id reached a barrier |
| bar_arrive_id | input | WID | Slot arriving at a barrier |
| bar_release_mask | input | NUM_WARPS | Per-slot barrier release, bit i for slot i |
| issue_vld | output | 1 | A warp is issued this cycle |
| issue_id | output | WID | Slot issued this cycle |

## Verification
The first pattern has three warps that are all ready. This confirms the plain rotation and back-to-back issue. A run that uses the top slot then checks wrap-around. Miss and barrier blocking are applied to one warp while the others keep issuing. This shows whether blocked slots are skipped without stalling the rotation, and whether they rejoin after the fill or the release. Events that collide in the same cycle (miss with fill, arrival with release, launch with exit) tell the intended priority apart from its reverse. Retiring every warp distinguishes a correct idle cycle, with the pointer held, from a spurious issue.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef struct packed {
    logic launch;
    logic retire;
    logic miss;
    logic fill;
    logic arrive;
    logic release_b;
  } slot_evt_t;

endpackage

// File: rtl/wsched_slot.sv
module wsched_slot
  import wsched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slot_evt_t evt,
  output logic      active_o,
  output logic      miss_o,
  output logic      bar_o,
  output logic      ready_o
);

  logic active_q, active_d;
  logic miss_q, miss_d;
  logic bar_q, bar_d;
  logic upd_en;

  always_comb begin
    active_d = active_q;
    miss_d   = miss_q;
    bar_d    = bar_q;
    if (evt.launch) begin
      active_d = 1'b1;
      miss_d   = 1'b0;
      bar_d    = 1'b0;
    end else begin
      if (evt.retire) begin
        active_d = 1'b0;
      end
      if (evt.fill) begin
        miss_d = 1'b0;
      end else if (evt.miss && active_q) begin
        miss_d = 1'b1;
      end
      if (evt.release_b) begin
        bar_d = 1'b0;
      end else if (evt.arrive && active_q) begin
        bar_d = 1'b1;
      end
    end
  end

  assign upd_en = (active_d != active_q) || (miss_d != miss_q) || (bar_d != bar_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      miss_q   <= 1'b0;
      bar_q    <= 1'b0;
    end else if (upd_en) begin
      active_q <= active_d;
      miss_q   <= miss_d;
      bar_q    <= bar_d;
    end
  end

  assign active_o = active_q;
  assign miss_o   = miss_q;
  assign bar_o    = bar_q;
  assign ready_o  = active_q && !miss_q && !bar_q;

endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int NUM_WARPS = 16,
  parameter int WID       = 4
) (
  input  logic [NUM_WARPS-1:0] ready,
  input  logic [WID-1:0]       ptr,
  output logic                 found,
  output logic [WID-1:0]       pick
);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      int k;
      k = (int'(ptr) + i) % NUM_WARPS;
      if (!found && ready[k]) begin
        found = 1'b1;
        pick  = WID'(k);
      end
    end
  end

endmodule

// File: rtl/wsched_rr_ptr.sv
module wsched_rr_ptr #(
  parameter int NUM_WARPS = 16,
  parameter int WID       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [WID-1:0] last,
  output logic [WID-1:0] ptr
);

  logic [WID-1:0] ptr_q, ptr_d;

  always_comb begin
    if (last == WID'(NUM_WARPS - 1)) begin
      ptr_d = '0;
    end else begin
      ptr_d = last + WID'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  localparam int WID = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_vld,
  input  logic [WID-1:0]       launch_id,
  input  logic                 exit_vld,
  input  logic [WID-1:0]       exit_id,
  input  logic                 miss_vld,
  input  logic [WID-1:0]       miss_id,
  input  logic                 fill_vld,
  input  logic [WID-1:0]       fill_id,
  input  logic                 bar_arrive_vld,
  input  logic [WID-1:0]       bar_arrive_id,
  input  logic [NUM_WARPS-1:0] bar_release_mask,
  output logic                 issue_vld,
  output logic [WID-1:0]       issue_id
);

  logic [NUM_WARPS-1:0] active_vec;
  logic [NUM_WARPS-1:0] miss_vec;
  logic [NUM_WARPS-1:0] bar_vec;
  logic [NUM_WARPS-1:0] ready_vec;
  logic [WID-1:0]       rr_ptr;
  logic                 pick_found;
  logic [WID-1:0]       pick_id;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    slot_evt_t evt;
    always_comb begin
      evt.launch    = launch_vld     && (launch_id     == WID'(g));
      evt.retire    = exit_vld       && (exit_id       == WID'(g));
      evt.miss      = miss_vld       && (miss_id       == WID'(g));
      evt.fill      = fill_vld       && (fill_id       == WID'(g));
      evt.arrive    = bar_arrive_vld && (bar_arrive_id == WID'(g));
      evt.release_b = bar_release_mask[g];
    end
    wsched_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .active_o (active_vec[g]),
      .miss_o   (miss_vec[g]),
      .bar_o    (bar_vec[g]),
      .ready_o  (ready_vec[g])
    );
  end

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID(WID)) u_pick (
    .ready (ready_vec),
    .ptr   (rr_ptr),
    .found (pick_found),
    .pick  (pick_id)
  );

  wsched_rr_ptr #(.NUM_WARPS(NUM_WARPS), .WID(WID)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pick_found),
    .last  (pick_id),
    .ptr   (rr_ptr)
  );

  assign issue_vld = pick_found;
  assign issue_id  = pick_id;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 16,
  parameter int WID       = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 launch_vld,
  input logic [WID-1:0]       launch_id,
  input logic                 miss_vld,
  input logic [WID-1:0]       miss_id,
  input logic                 fill_vld,
  input logic [WID-1:0]       fill_id,
  input logic                 bar_arrive_vld,
  input logic [WID-1:0]       bar_arrive_id,
  input logic [NUM_WARPS-1:0] bar_release_mask,
  input logic                 issue_vld,
  input logic [WID-1:0]       issue_id,
  input logic [NUM_WARPS-1:0] active_vec,
  input logic [NUM_WARPS-1:0] miss_vec,
  input logic [NUM_WARPS-1:0] bar_vec,
  input logic [WID-1:0]       rr_ptr
);

  AST_ISSUE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> active_vec[issue_id]); // R9

  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vec == '0) |-> !issue_vld); // R8

  AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> (rr_ptr == (($past(issue_id) == WID'(NUM_WARPS-1)) ? '0 : $past(issue_id) + WID'(1)))); // R3

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(rr_ptr)); // R8

  AST_MISS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && active_vec[miss_id] && !(fill_vld && fill_id == miss_id)
     && !(launch_vld && launch_id == miss_id))
    |=> !(issue_vld && issue_id == $past(miss_id))); // R4

  AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && fill_vld && miss_id == fill_id) |=> !miss_vec[$past(fill_id)]); // R5

  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_arrive_vld && active_vec[bar_arrive_id] && !bar_release_mask[bar_arrive_id]
     && !(launch_vld && launch_id == bar_arrive_id))
    |=> bar_vec[$past(bar_arrive_id)]); // R6

  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_arrive_vld && bar_release_mask[bar_arrive_id]) |=> !bar_vec[$past(bar_arrive_id)]); // R7

endmodule

bind warp_issue_sched warp_issue_sched_chk #(.NUM_WARPS(NUM_WARPS), .WID(WID)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .launch_vld       (launch_vld),
  .launch_id        (launch_id),
  .miss_vld         (miss_vld),
  .miss_id          (miss_id),
  .fill_vld         (fill_vld),
  .fill_id          (fill_id),
  .bar_arrive_vld   (bar_arrive_vld),
  .bar_arrive_id    (bar_arrive_id),
  .bar_release_mask (bar_release_mask),
  .issue_vld        (issue_vld),
  .issue_id         (issue_id),
  .active_vec       (active_vec),
  .miss_vec         (miss_vec),
  .bar_vec          (bar_vec),
  .rr_ptr           (rr_ptr)
);

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;

  localparam int N   = 16;
  localparam int WID = 4;

  logic           clk;
  logic           rst_n;
  logic           launch_vld, exit_vld, miss_vld, fill_vld, bar_arrive_vld;
  logic [WID-1:0] launch_id, exit_id, miss_id, fill_id, bar_arrive_id;
  logic [N-1:0]   bar_release_mask;
  logic           issue_vld;
  logic [WID-1:0] issue_id;

  int checks;
  int failures;
  bit finished;

  logic [N-1:0] m_act, m_miss, m_bar;
  int           m_ptr;

  warp_issue_sched #(.NUM_WARPS(N)) dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .launch_vld       (launch_vld),
    .launch_id        (launch_id),
    .exit_vld         (exit_vld),
    .exit_id          (exit_id),
    .miss_vld         (miss_vld),
    .miss_id          (miss_id),
    .fill_vld         (fill_vld),
    .fill_id          (fill_id),
    .bar_arrive_vld   (bar_arrive_vld),
    .bar_arrive_id    (bar_arrive_id),
    .bar_release_mask (bar_release_mask),
    .issue_vld        (issue_vld),
    .issue_id         (issue_id)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pick();
    for (int i = 0; i < N; i++) begin
      int k;
      k = (m_ptr + i) % N;
      if (m_act[k] && !m_miss[k] && !m_bar[k]) return k;
    end
    return -1;
  endfunction

  task automatic clear_in();
    launch_vld = 0; exit_vld = 0; miss_vld = 0; fill_vld = 0; bar_arrive_vld = 0;
    launch_id = '0; exit_id = '0; miss_id = '0; fill_id = '0; bar_arrive_id = '0;
    bar_release_mask = '0;
  endtask

  // Called just after a falling edge with inputs set: compare, then advance one cycle.
  task automatic tick(string req);
    int e;
    int got;
    e = exp_pick();
    got = issue_vld ? int'(issue_id) : -1;
    chk(req, got == e, got, e);
    @(posedge clk);
    if (e >= 0) m_ptr = (e + 1) % N;
    for (int w = 0; w < N; w++) begin
      bit l, x, ms, f, a, r;
      l  = launch_vld && int'(launch_id) == w;
      x  = exit_vld && int'(exit_id) == w;
      ms = miss_vld && int'(miss_id) == w;
      f  = fill_vld && int'(fill_id) == w;
      a  = bar_arrive_vld && int'(bar_arrive_id) == w;
      r  = bar_release_mask[w];
      if (l) begin
        m_act[w] = 1; m_miss[w] = 0; m_bar[w] = 0;
      end else begin
        if (f) m_miss[w] = 0;
        else if (ms && m_act[w]) m_miss[w] = 1;
        if (r) m_bar[w] = 0;
        else if (a && m_act[w]) m_bar[w] = 1;
        if (x) m_act[w] = 0;
      end
    end
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    chk("R1", issue_vld == 1'b0, int'(issue_vld), 0);
    tick("R8");
    tick("R1");
  endtask

  task automatic t_basic();
    launch_vld = 1; launch_id = 4'd0; tick("R9");
    launch_vld = 1; launch_id = 4'd1; tick("R2");
    launch_vld = 1; launch_id = 4'd2; tick("R2");
    // ready {0,1,2}, pointer after slot 1 -> 2, then 0, 1, 2
    chk("R3", issue_vld && issue_id == 4'd2, int'(issue_id), 2);
    tick("R3");
    chk("R3", issue_vld && issue_id == 4'd0, int'(issue_id), 0);
    tick("R3");
    chk("R2", issue_vld && issue_id == 4'd1, int'(issue_id), 1);
    for (int i = 0; i < 4; i++) tick("R2");
  endtask

  task automatic t_miss();
    miss_vld = 1; miss_id = 4'd1; tick("R4");
    for (int i = 0; i < 6; i++) begin
      chk("R4", !(issue_vld && issue_id == 4'd1), int'(issue_id), -1);
      tick("R4");
    end
    fill_vld = 1; fill_id = 4'd1; tick("R4");
    for (int i = 0; i < 4; i++) tick("R4");
  endtask

  task automatic t_same_cycle_fill();
    miss_vld = 1; miss_id = 4'd2; fill_vld = 1; fill_id = 4'd2; tick("R5");
    for (int i = 0; i < 4; i++) tick("R5");
  endtask

  task automatic t_barrier();
    bar_arrive_vld = 1; bar_arrive_id = 4'd0; tick("R6");
    for (int i = 0; i < 5; i++) begin
      chk("R6", !(issue_vld && issue_id == 4'd0), int'(issue_id), -1);
      tick("R6");
    end
    bar_release_mask = 16'h0001; tick("R6");
    for (int i = 0; i < 3; i++) tick("R6");
    bar_arrive_vld = 1; bar_arrive_id = 4'd1; bar_release_mask = 16'h0002; tick("R7");
    for (int i = 0; i < 4; i++) tick("R7");
  endtask

  task automatic t_wrap();
    launch_vld = 1; launch_id = 4'd15; tick("R3");
    for (int i = 0; i < 8; i++) tick("R3");
  endtask

  task automatic t_exit();
    exit_vld = 1; exit_id = 4'd0; tick("R9");
    for (int i = 0; i < 6; i++) begin
      chk("R9", !(issue_vld && issue_id == 4'd0), int'(issue_id), -1);
      tick("R9");
    end
  endtask

  task automatic t_launch_exit();
    int seen;
    seen = 0;
    launch_vld = 1; launch_id = 4'd5; exit_vld = 1; exit_id = 4'd5; tick("R10");
    for (int i = 0; i < 6; i++) begin
      if (issue_vld && issue_id == 4'd5) seen++;
      tick("R10");
    end
    chk("R10", seen > 0, seen, 1);
  endtask

  task automatic t_empty();
    // block 15 by a miss, then retire all others; nothing is ready
    miss_vld = 1; miss_id = 4'd15; tick("R8");
    for (int w = 0; w < N; w++) begin
      if (w != 15 && m_act[w]) begin
        exit_vld = 1; exit_id = WID'(w); tick("R8");
      end
    end
    tick("R8");
    chk("R8", issue_vld == 1'b0, int'(issue_vld), 0);
    tick("R8");
    tick("R8");
    // a stale fill re-enables 15; pointer was held so 15 issues
    fill_vld = 1; fill_id = 4'd15; tick("R4");
    chk("R8", issue_vld && issue_id == 4'd15, int'(issue_id), 15);
    tick("R3");
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0;
    m_act = '0; m_miss = '0; m_bar = '0; m_ptr = 0;
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_miss();
    t_same_cycle_fill();
    t_barrier();
    t_wrap();
    t_exit();
    t_launch_exit();
    t_empty();
    report();
  end

endmodule